// File: doc/BRIEF.md
# Silicon Strip Hit Clusterer

This block turns streams of silicon strip hits into clusters. Eight lanes run side by side, one per sensor input. Axial and stereo sensors use the same logic. Each lane accepts at most one hit per cycle. A hit carries a strip address and an 8-bit raw pulse height, and the hits of one event arrive in ascending strip order. An end-of-event strobe separates events.

Each lane has three small tables indexed by strip address: a bad-strip flag, a pedestal and a gain. Every hit is looked up in them. A hit on a flagged strip is thrown away. Otherwise the pedestal is subtracted from the pulse height, the result is scaled by the gain, and it is clamped to the 8-bit range. Corrected hits below a fixed threshold are dropped. Surviving hits on consecutive strips are merged into one cluster. For each cluster the lane reports a charge-weighted centroid, a total charge and a width in strips.

The tables are loaded through a shared write port. Writes are made only while no hits are being presented. A table read takes one cycle, and this cycle sits in the lane's first pipeline stage.

Top module: `strip_cluster_array`

## Requirements
- R1: A hit whose strip has a bad-strip entry of 1 (bit 0 of the written data) adds nothing to any cluster, starts no cluster and produces no output. Because it is not kept, the next kept hit is not adjacent to the hit before the bad strip.
- R2: The corrected amplitude is min(255, floor(max(0, adc - pedestal) * gain / 64)), where gain is unsigned with 2 integer and 6 fractional bits. It is 0 when adc does not exceed the pedestal.
- R3: A hit whose corrected amplitude is below THRESH (default 8) is dropped. Every reported cluster therefore has a charge of at least THRESH times its width.
- R4: A kept hit whose strip is exactly one above the previous kept hit of the open cluster extends that cluster. An extending hit produces no output in the cycle it is absorbed.
- R5: An open cluster is closed and reported when a kept hit arrives that does not extend it, or when hit_eoe is asserted. In a cycle with hit_eoe asserted, the hit fields of that lane are ignored.
- R6: A reported cluster gives the charge as the sum of corrected amplitudes and the width as the number of kept strips. The centroid is round-half-up(4 * sum(amp * strip) / charge), which is the strip position with 2 fractional bits. clu_valid is a one-cycle pulse registered at the clock edge after the edge that samples the closing input.
- R7: A run of more than MAXW (default 8) consecutive kept strips is split into pieces of MAXW strips, with the remainder as the last piece. Every piece of such a run has clu_oversize set. Clusters of MAXW strips or fewer have it clear.
- R8: The eight lanes work independently and at the same time. Each lane has its own tables, and hits on different lanes in the same cycle do not interact.
- R9: A write with tbl_we=1 stores tbl_data in lane tbl_lane at strip tbl_addr. tbl_kind selects the table: 0 is the bad-strip flag, 1 is the pedestal, 2 is the gain, and 3 writes nothing. The value is used by hits presented after the write. tbl_we is never asserted together with any hit_valid.
- R10: While rst_n is low, and after it rises, no clu_valid is asserted. A cluster that was open at reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_kind | input | 2 | Table select: 0 bad-strip, 1 pedestal, 2 gain |
| tbl_lane | input | 3 | Lane whose table is written |
| tbl_addr | input | 6 | Strip address of the table entry |
| tbl_data | input | 8 | Table write data |
| hit_valid | input | 8 | Per-lane hit strobe |
| hit_eoe | input | 8 | Per-lane end-of-event strobe |
| hit_strip | input | 48 | Per-lane strip address, 6 bits per lane |
| hit_adc | input | 64 | Per-lane raw pulse height, 8 bits per lane |
| clu_valid | output | 8 | Per-lane cluster strobe |
| clu_centroid | output | 64 | Per-lane centroid, 8 bits (6 integer, 2 fractional) per lane |
| clu_charge | output | 88 | Per-lane summed charge, 11 bits per lane |
| clu_width | output | 32 | Per-lane width in strips, 4 bits per lane |
| clu_oversize | output | 8 | Per-lane split-run flag |

## Verification
A wrong open flag, last-strip register or width count shows up at the ports within one cycle of the next kept hit. It appears as a cluster emitted where an extension was due, or as two clusters merged, and the in-order scoreboard reports it as a missing, extra or mismatched item. A wrong table entry or a bad correction changes the charge and the centroid of the very next cluster that contains that strip. A lost end-of-event close leaves items in a lane's queue, and the check at the end of the run reports them.

// File: rtl/strip_clu_pkg.sv
package strip_clu_pkg;
  localparam int AMP_W     = 8;
  localparam int GAIN_FRAC = 6;
  localparam int PROD_W    = 2 * AMP_W;

  typedef enum logic [1:0] {
    TBL_MASK = 2'd0,
    TBL_PED  = 2'd1,
    TBL_GAIN = 2'd2
  } tbl_kind_e;

  // Subtract the pedestal, floor at zero, scale by the fixed-point gain,
  // and clamp to the amplitude range.
  function automatic logic [AMP_W-1:0] correct_amp(
    input logic [AMP_W-1:0] adc,
    input logic [AMP_W-1:0] ped,
    input logic [AMP_W-1:0] gain
  );
    logic [AMP_W-1:0]  diff;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    if (adc <= ped) return '0;
    diff   = adc - ped;
    prod   = PROD_W'(diff) * PROD_W'(gain);
    scaled = prod >> GAIN_FRAC;
    if (scaled > PROD_W'({AMP_W{1'b1}})) return {AMP_W{1'b1}};
    return scaled[AMP_W-1:0];
  endfunction
endpackage

// File: rtl/lane_tables.sv
module lane_tables
  import strip_clu_pkg::*;
#(
  parameter int STRIPS = 64,
  localparam int SW = $clog2(STRIPS)
) (
  input  logic             clk,
  input  logic             we_mask,
  input  logic             we_ped,
  input  logic             we_gain,
  input  logic [SW-1:0]    wr_addr,
  input  logic [AMP_W-1:0] wr_data,
  input  logic [SW-1:0]    rd_addr,
  output logic             rd_bad,
  output logic [AMP_W-1:0] rd_ped,
  output logic [AMP_W-1:0] rd_gain
);
  logic             bad_mem  [STRIPS];
  logic [AMP_W-1:0] ped_mem  [STRIPS];
  logic [AMP_W-1:0] gain_mem [STRIPS];

  // Synchronous read: the data arrives one cycle after the address.
  always_ff @(posedge clk) begin
    if (we_mask) bad_mem[wr_addr]  <= wr_data[0];
    if (we_ped)  ped_mem[wr_addr]  <= wr_data;
    if (we_gain) gain_mem[wr_addr] <= wr_data;
    rd_bad  <= bad_mem[rd_addr];
    rd_ped  <= ped_mem[rd_addr];
    rd_gain <= gain_mem[rd_addr];
  end
endmodule

// File: rtl/cluster_builder.sv
module cluster_builder
  import strip_clu_pkg::*;
#(
  parameter int STRIPS = 64,
  parameter int MAXW   = 8,
  parameter int THRESH = 8,
  localparam int SW  = $clog2(STRIPS),
  localparam int CW  = SW + 2,
  localparam int QW  = AMP_W + $clog2(MAXW),
  localparam int QXW = QW + SW,
  localparam int WW  = $clog2(MAXW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_eoe,
  input  logic [SW-1:0]    in_strip,
  input  logic [AMP_W-1:0] in_amp,
  input  logic             in_bad,
  output logic             out_valid,
  output logic [CW-1:0]    out_centroid,
  output logic [QW-1:0]    out_charge,
  output logic [WW-1:0]    out_width,
  output logic             out_over
);
  logic           open_q;
  logic [SW-1:0]  last_q;
  logic [WW-1:0]  wid_q;
  logic [QW-1:0]  sum_q;
  logic [QXW-1:0] sumx_q;
  logic           ovf_q;

  // Charge-weighted mean with two fractional bits, rounded half up.
  function automatic logic [CW-1:0] centroid(input logic [QW-1:0] q,
                                             input logic [QXW-1:0] qx);
    logic [QXW+2:0] num;
    logic [QXW+2:0] res;
    if (q == '0) return '0;
    num = (QXW+3)'({qx, 2'b00}) + (QXW+3)'(q >> 1);
    res = num / (QXW+3)'(q);
    return res[CW-1:0];
  endfunction

  // Named internal events
  wire ev_keep   = in_valid && !in_bad && (in_amp >= AMP_W'(THRESH));
  wire ev_adj    = open_q && ({1'b0, in_strip} == ({1'b0, last_q} + 1'b1));
  wire ev_extend = ev_keep && ev_adj && (wid_q < WW'(MAXW));
  wire ev_split  = ev_keep && ev_adj && (wid_q == WW'(MAXW));
  wire ev_emit   = open_q && (in_eoe || (ev_keep && !ev_extend));

  wire [QXW-1:0] amp_x_strip = QXW'(in_amp) * QXW'(in_strip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q       <= 1'b0;
      last_q       <= '0;
      wid_q        <= '0;
      sum_q        <= '0;
      sumx_q       <= '0;
      ovf_q        <= 1'b0;
      out_valid    <= 1'b0;
      out_centroid <= '0;
      out_charge   <= '0;
      out_width    <= '0;
      out_over     <= 1'b0;
    end else begin
      out_valid <= ev_emit;
      if (ev_emit) begin
        out_centroid <= centroid(sum_q, sumx_q);
        out_charge   <= sum_q;
        out_width    <= wid_q;
        out_over     <= ovf_q | ev_split;
      end
      if (in_eoe) begin
        open_q <= 1'b0;
      end else if (ev_keep) begin
        open_q <= 1'b1;
        last_q <= in_strip;
        if (ev_extend) begin
          wid_q  <= wid_q + 1'b1;
          sum_q  <= sum_q + QW'(in_amp);
          sumx_q <= sumx_q + amp_x_strip;
        end else begin
          wid_q  <= WW'(1);
          sum_q  <= QW'(in_amp);
          sumx_q <= amp_x_strip;
          ovf_q  <= ev_split;
        end
      end
    end
  end

  // R1
  drop_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_eoe && in_bad) |=> !out_valid);
  // R4
  extend_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_extend |=> !out_valid);
  // R7
  width_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_width >= WW'(1) && out_width <= WW'(MAXW)));
  // R3
  charge_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_charge >= QW'(out_width) * QW'(THRESH)));
endmodule

// File: rtl/strip_lane.sv
module strip_lane
  import strip_clu_pkg::*;
#(
  parameter int STRIPS = 64,
  parameter int MAXW   = 8,
  parameter int THRESH = 8,
  localparam int SW = $clog2(STRIPS),
  localparam int CW = SW + 2,
  localparam int QW = AMP_W + $clog2(MAXW),
  localparam int WW = $clog2(MAXW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [SW-1:0]    wr_addr,
  input  logic [AMP_W-1:0] wr_data,
  input  logic             hit_valid,
  input  logic             hit_eoe,
  input  logic [SW-1:0]    hit_strip,
  input  logic [AMP_W-1:0] hit_adc,
  output logic             clu_valid,
  output logic [CW-1:0]    clu_centroid,
  output logic [QW-1:0]    clu_charge,
  output logic [WW-1:0]    clu_width,
  output logic             clu_oversize
);
  logic             s1_valid, s1_eoe;
  logic [SW-1:0]    s1_strip;
  logic [AMP_W-1:0] s1_adc;
  logic             t_bad;
  logic [AMP_W-1:0] t_ped, t_gain;
  logic [AMP_W-1:0] s1_amp;

  lane_tables #(.STRIPS(STRIPS)) tables_i (
    .clk     (clk),
    .we_mask (wr_en && wr_kind == TBL_MASK),
    .we_ped  (wr_en && wr_kind == TBL_PED),
    .we_gain (wr_en && wr_kind == TBL_GAIN),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (hit_strip),
    .rd_bad  (t_bad),
    .rd_ped  (t_ped),
    .rd_gain (t_gain)
  );

  // Stage 1 holds the hit while its table entries are read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_eoe   <= 1'b0;
      s1_strip <= '0;
      s1_adc   <= '0;
    end else begin
      s1_valid <= hit_valid && !hit_eoe;
      s1_eoe   <= hit_eoe;
      s1_strip <= hit_strip;
      s1_adc   <= hit_adc;
    end
  end

  assign s1_amp = correct_amp(s1_adc, t_ped, t_gain);

  cluster_builder #(.STRIPS(STRIPS), .MAXW(MAXW), .THRESH(THRESH)) build_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (s1_valid),
    .in_eoe       (s1_eoe),
    .in_strip     (s1_strip),
    .in_amp       (s1_amp),
    .in_bad       (t_bad),
    .out_valid    (clu_valid),
    .out_centroid (clu_centroid),
    .out_charge   (clu_charge),
    .out_width    (clu_width),
    .out_over     (clu_oversize)
  );
endmodule

// File: rtl/strip_cluster_array.sv
module strip_cluster_array
  import strip_clu_pkg::*;
#(
  parameter int NLANE  = 8,
  parameter int STRIPS = 64,
  parameter int MAXW   = 8,
  parameter int THRESH = 8,
  localparam int LW = $clog2(NLANE),
  localparam int SW = $clog2(STRIPS),
  localparam int CW = SW + 2,
  localparam int QW = AMP_W + $clog2(MAXW),
  localparam int WW = $clog2(MAXW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tbl_we,
  input  logic [1:0]             tbl_kind,
  input  logic [LW-1:0]          tbl_lane,
  input  logic [SW-1:0]          tbl_addr,
  input  logic [AMP_W-1:0]       tbl_data,
  input  logic [NLANE-1:0]       hit_valid,
  input  logic [NLANE-1:0]       hit_eoe,
  input  logic [NLANE*SW-1:0]    hit_strip,
  input  logic [NLANE*AMP_W-1:0] hit_adc,
  output logic [NLANE-1:0]       clu_valid,
  output logic [NLANE*CW-1:0]    clu_centroid,
  output logic [NLANE*QW-1:0]    clu_charge,
  output logic [NLANE*WW-1:0]    clu_width,
  output logic [NLANE-1:0]       clu_oversize
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    strip_lane #(.STRIPS(STRIPS), .MAXW(MAXW), .THRESH(THRESH)) lane_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (tbl_we && (tbl_lane == LW'(g))),
      .wr_kind      (tbl_kind),
      .wr_addr      (tbl_addr),
      .wr_data      (tbl_data),
      .hit_valid    (hit_valid[g]),
      .hit_eoe      (hit_eoe[g]),
      .hit_strip    (hit_strip[g*SW +: SW]),
      .hit_adc      (hit_adc[g*AMP_W +: AMP_W]),
      .clu_valid    (clu_valid[g]),
      .clu_centroid (clu_centroid[g*CW +: CW]),
      .clu_charge   (clu_charge[g*QW +: QW]),
      .clu_width    (clu_width[g*WW +: WW]),
      .clu_oversize (clu_oversize[g])
    );
  end

  // R9
  tbl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (hit_valid == '0));
  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (clu_valid == '0));
endmodule

// File: tb/strip_cluster_array_tb_top.sv
module strip_cluster_array_tb_top;
  localparam int NL = 8, SW = 6, CW = 8, QW = 11, WW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tbl_we = 1'b0;
  logic [1:0] tbl_kind = '0;
  logic [2:0] tbl_lane = '0;
  logic [SW-1:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic [NL-1:0] hit_valid = '0, hit_eoe = '0;
  logic [NL*SW-1:0] hit_strip = '0;
  logic [NL*8-1:0] hit_adc = '0;
  logic [NL-1:0] clu_valid, clu_oversize;
  logic [NL*CW-1:0] clu_centroid;
  logic [NL*QW-1:0] clu_charge;
  logic [NL*WW-1:0] clu_width;

  always #2 clk = ~clk;

  strip_cluster_array dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_kind(tbl_kind),
    .tbl_lane(tbl_lane), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .hit_valid(hit_valid), .hit_eoe(hit_eoe), .hit_strip(hit_strip),
    .hit_adc(hit_adc), .clu_valid(clu_valid), .clu_centroid(clu_centroid),
    .clu_charge(clu_charge), .clu_width(clu_width), .clu_oversize(clu_oversize)
  );

  typedef struct { int cen; int q; int w; bit ov; string tag; } exp_t;
  exp_t exp_q [NL][$];

  int checks = 0, errors = 0, seen = 0;
  string cur_tag = "R6";

  int t_bad [NL][64];
  int t_ped [NL][64];
  int t_gain[NL][64];
  bit m_open[NL];
  int m_last[NL], m_w[NL], m_q[NL], m_qx[NL];
  bit m_ov[NL];

  // Model of the amplitude correction, written as integer arithmetic (R2).
  function automatic int corr(int adc, int p, int g);
    int v;
    v = adc - p;
    if (v < 0) v = 0;
    v = (v * g) / 64;
    return (v > 255) ? 255 : v;
  endfunction

  task automatic m_emit(int l, bit ov);
    exp_t e;
    e.q = m_q[l]; e.w = m_w[l]; e.ov = ov;
    e.cen = (8 * m_qx[l] + m_q[l]) / (2 * m_q[l]);
    e.tag = ov ? "R7" : cur_tag;
    exp_q[l].push_back(e);
  endtask

  task automatic m_hit(int l, int s, int adc);
    int a;
    bit adj;
    a = corr(adc, t_ped[l][s], t_gain[l][s]);
    if (t_bad[l][s] != 0 || a < 8) return;
    adj = m_open[l] && (s == m_last[l] + 1);
    if (adj && m_w[l] < 8) begin
      m_w[l]++; m_q[l] += a; m_qx[l] += a * s;
    end else begin
      if (m_open[l]) m_emit(l, m_ov[l] | adj);
      m_open[l] = 1; m_w[l] = 1; m_q[l] = a; m_qx[l] = a * s; m_ov[l] = adj;
    end
    m_last[l] = s;
  endtask

  task automatic put_hit(int l, int s, int adc);
    hit_valid[l] = 1'b1;
    hit_strip[l*SW +: SW] = SW'(s);
    hit_adc[l*8 +: 8] = 8'(adc);
    m_hit(l, s, adc);
  endtask

  task automatic put_eoe(int l);
    hit_eoe[l] = 1'b1;
    if (m_open[l]) m_emit(l, m_ov[l]);
    m_open[l] = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    hit_valid = '0;
    hit_eoe = '0;
  endtask

  task automatic wr(int kind, int l, int a, int d);
    tbl_we = 1'b1; tbl_kind = 2'(kind); tbl_lane = 3'(l);
    tbl_addr = SW'(a); tbl_data = 8'(d);
    if (kind == 0) t_bad[l][a] = d & 1;
    if (kind == 1) t_ped[l][a] = d;
    if (kind == 2) t_gain[l][a] = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pops expected clusters in order and compares the fields.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < NL; l++) begin
        if (clu_valid[l]) begin
          int ac, aq, aw;
          bit ao;
          exp_t e;
          ac = int'(clu_centroid[l*CW +: CW]);
          aq = int'(clu_charge[l*QW +: QW]);
          aw = int'(clu_width[l*WW +: WW]);
          ao = clu_oversize[l];
          seen++;
          checks++;
          if (exp_q[l].size() == 0) begin
            errors++;
            $display("FAIL R5 lane %0d unexpected cluster cen=%0d q=%0d w=%0d expected none",
                     l, ac, aq, aw);
          end else begin
            e = exp_q[l].pop_front();
            if (ac != e.cen || aq != e.q || aw != e.w || ao != e.ov) begin
              errors++;
              $display("FAIL %s lane %0d cen=%0d q=%0d w=%0d ov=%0d expected cen=%0d q=%0d w=%0d ov=%0d",
                       e.tag, l, ac, aq, aw, ao, e.cen, e.q, e.w, e.ov);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    int s, seen0;
    for (int l = 0; l < NL; l++) m_open[l] = 0;
    repeat (3) @(negedge clk);
    // R10: quiet during reset
    checks++;
    if (clu_valid != '0) begin
      errors++;
      $display("FAIL R10 clu_valid=%0h expected 0 in reset", clu_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R9: load every table entry of every lane.
    for (int l = 0; l < NL; l++)
      for (int a = 0; a < 64; a++) begin
        wr(0, l, a, (l == 0 && a == 5) ? 1 : 0);
        wr(1, l, a, 10);
        wr(2, l, a, 64);
      end

    // R4/R6: two adjacent strips, closed by end of event.
    cur_tag = "R4";
    put_hit(0, 3, 50); tick();
    put_hit(0, 4, 90); tick();
    put_eoe(0); tick(); drain();

    // R1: strip 5 bad; strips 4 and 6 become separate clusters.
    cur_tag = "R1";
    put_hit(0, 4, 60); tick();
    put_hit(0, 5, 200); tick();
    put_hit(0, 6, 70); tick();
    put_eoe(0); tick(); drain();

    // R3: a hit below threshold (corr 7) splits a run; a hit at threshold survives.
    cur_tag = "R3";
    put_hit(1, 10, 40); tick();
    put_hit(1, 11, 17); tick();
    put_hit(1, 12, 18); tick();
    put_eoe(1); tick(); drain();

    // R2: saturation and pedestal floor.
    cur_tag = "R2";
    wr(1, 2, 20, 0); wr(2, 2, 20, 255);
    wr(2, 2, 21, 100);
    put_hit(2, 20, 255); tick();
    put_hit(2, 21, 200); tick();
    put_hit(2, 23, 9); tick();
    put_hit(2, 30, 37); tick();
    put_eoe(2); tick(); drain();

    // R5: a gap closes the cluster without an end-of-event; hit fields ignored with eoe.
    cur_tag = "R5";
    put_hit(3, 0, 30); tick();
    put_hit(3, 2, 30); tick();
    put_hit(3, 3, 100); tick();
    hit_valid[3] = 1'b1; hit_strip[3*SW +: SW] = 6'd4; hit_adc[3*8 +: 8] = 8'd99;
    put_eoe(3); tick(); drain();

    // R7: run of 19 strips -> pieces 8, 8, 3, all flagged; then a short cluster unflagged.
    cur_tag = "R6";
    for (int k = 0; k < 19; k++) begin put_hit(4, 40 + k, 20 + 3 * k); tick(); end
    put_hit(4, 61, 80); tick();
    put_eoe(4); tick(); drain();

    // R8: all lanes in the same cycles with different patterns.
    cur_tag = "R8";
    for (int k = 0; k < 6; k++) begin
      for (int l = 0; l < NL; l++)
        if (((k + l) % 3) != 0) put_hit(l, 8 * l + k, 30 + 10 * l + k);
      tick();
    end
    for (int l = 0; l < NL; l++) put_eoe(l);
    tick(); drain();

    // R9: rewrite one pedestal and gain, then use them.
    cur_tag = "R9";
    wr(1, 6, 33, 40); wr(2, 6, 33, 128); wr(3, 6, 33, 0);
    put_hit(6, 33, 100); tick();
    put_eoe(6); tick(); drain();

    // R10: a cluster open at reset is discarded.
    cur_tag = "R10";
    put_hit(5, 10, 60); tick();
    put_hit(5, 11, 60); tick();
    seen0 = seen;
    rst_n = 1'b0;
    for (int l = 0; l < NL; l++) m_open[l] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    put_eoe(5); tick(); drain();
    checks++;
    if (seen != seen0) begin
      errors++;
      $display("FAIL R10 clusters after reset=%0d expected 0", seen - seen0);
    end

    // R8: random tables and ascending random events on all lanes.
    cur_tag = "R8";
    for (int l = 0; l < NL; l++)
      for (int a = 0; a < 64; a++) begin
        wr(0, l, a, ($urandom_range(0, 15) == 0) ? 1 : 0);
        wr(1, l, a, $urandom_range(0, 30));
        wr(2, l, a, $urandom_range(40, 180));
      end
    for (int ev = 0; ev < 60; ev++) begin
      int cur[NL];
      for (int l = 0; l < NL; l++) cur[l] = $urandom_range(0, 6);
      for (int c = 0; c < 40; c++) begin
        for (int l = 0; l < NL; l++)
          if (cur[l] < 64) begin
            put_hit(l, cur[l], $urandom_range(0, 255));
            cur[l] += ($urandom_range(0, 3) == 0) ? 2 : 1;
          end
        tick();
      end
      for (int l = 0; l < NL; l++) put_eoe(l);
      tick();
    end
    drain();

    // R5: every expected cluster was produced.
    for (int l = 0; l < NL; l++) begin
      checks++;
      if (exp_q[l].size() != 0) begin
        errors++;
        $display("FAIL R5 lane %0d pending=%0d expected 0", l, exp_q[l].size());
      end
    end
    s = 0;
    finish_run();
  end
endmodule